// File: doc/BRIEF.md
# Three-Stage Prescaled Watchdog

This block is one watchdog channel for a large chip. Software programs a configuration word that holds a stage limit, a 16-bit length and two stop enables. A free core clock is divided by a fixed power-of-two prescaler, and each prescaler tick moves a down-counter one step. The counter's reload value is the length placed above a field of zero low bits, so software sets the timeout in coarse steps. Each time the counter runs out, the channel enters its next expiry stage: a first interrupt, then a second interrupt, then a reset request. After each expiry the counter reloads, so every stage lasts one full period.

A write to the separate poke strobe shows that the software is still running. The poke reloads the counter, restarts the prescaler and returns the channel to its armed stage. The stage limit decides how far the sequence may go. Zero means off. One stops after the first interrupt and two stops after the second. Three allows the reset request. Two halt inputs, one for debug and one for a global stop, freeze the countdown while they are high, but only when their enable bits are set. All stored state is visible through a read-back word.

Top module: `wdg_tristage`

## Requirements
- R1: After reset, `irq_stage1`, `irq_stage2` and `rst_req` are low and `cfg_rdata` reads zero.
- R2: The read-back word holds the stage limit in bits [1:0], the current stage in bits [3:2], the length in bits [19:4], the live count in bits [43:20], the debug-stop enable in bit 44 and the global-stop enable in bit 45. On the cycle after a configuration write, the stage reads 0 and the count reads length × 2^LOW_W.
- R3: When the count is loaded with value V and then counts without a halt, the next expiry happens (V+1) × 2^PRE_LOG2 clock edges after the load edge.
- R4: The first expiry pulses `irq_stage1` high for one clock. The next pulses `irq_stage2` high for one clock. The third raises `rst_req`. Each expiry reloads the count, and the stage moves from 0 to 1, then 2, then 3.
- R5: With stage limit 1, the sequence stops after the `irq_stage1` pulse. With limit 2, it stops after the `irq_stage2` pulse. Neither limit raises `rst_req`, and the stage field holds at the limit.
- R6: Once set, `rst_req` stays high until the next configuration write.
- R7: A configuration write with stage limit 0, such as writing all zeros, clears `rst_req` on the next cycle. While the limit is 0, no interrupt or reset request is produced.
- R8: A pulse on `poke_we` reloads the count from the length, returns the stage to 0 and restarts the prescaler. The next expiry then follows the timing of R3. This also restarts a channel that has stopped at its stage limit.
- R9: While `dbg_halt` is high and bit 44 is set, the count and the prescaler hold, so the next expiry is delayed by exactly the number of halted edges. When bit 44 is clear, `dbg_halt` has no effect on expiry timing.
- R10: While `glb_halt` is high and bit 45 is set, the countdown holds in the same way, and expiry is delayed by the number of halted edges.
- R11: The stage field never exceeds the stage limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 64 | Configuration write data |
| cfg_rdata | output | 64 | Read-back of configuration, stage and live count |
| poke_we | input | 1 | Poke strobe; reloads and re-arms the channel |
| dbg_halt | input | 1 | Debug halt request |
| glb_halt | input | 1 | Global halt request |
| irq_stage1 | output | 1 | One-clock pulse on entry to stage 1 |
| irq_stage2 | output | 1 | One-clock pulse on entry to stage 2 |
| rst_req | output | 1 | Reset request; held high once stage 3 is reached |

## Verification
A wrong prescaler or counter value shifts the cycle at which an interrupt appears. The scoreboard pairs every event with an exact expected edge, so the error shows at the very first expiry, one period after the load. A stage register that skips or repeats shows up as an event of the wrong kind, or as an extra event, on the following expiry. A halt or poke that is mishandled moves the next event by the halt length, or by the distance to the poke. The live count field is read during halts, which shows within one cycle whether the counter is frozen.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

   localparam int REG_W      = 64;
   localparam int F_MODE_LO  = 0;
   localparam int F_STAGE_LO = 2;
   localparam int F_LEN_LO   = 4;
   localparam int F_CNT_LO   = 20;
   localparam int F_CNT_MAXW = 24;
   localparam int B_DSTOP    = 44;
   localparam int B_GSTOP    = 45;

   typedef enum logic [1:0] {
      STG_ARMED  = 2'd0,
      STG_FIRST  = 2'd1,
      STG_SECOND = 2'd2,
      STG_RESET  = 2'd3
   } wdg_stage_e;

endpackage

// File: rtl/wdg_prescale.sv
module wdg_prescale #(
   parameter int PRE_LOG2 = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   output logic tick
);

   generate
      if (PRE_LOG2 == 0) begin : g_direct
         assign tick = run;
      end else begin : g_div
         logic [PRE_LOG2-1:0] div_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               div_q <= '0;
            else if (clr)
               div_q <= '0;
            else if (run)
               div_q <= div_q + PRE_LOG2'(1);
         end

         assign tick = run && (&div_q);
      end
   endgenerate

endmodule

// File: rtl/wdg_countdown.sv
module wdg_countdown #(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   output logic [CNT_W-1:0] count,
   output logic             expire
);

   assign expire = tick && (count == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (load)
         count <= load_val;
      else if (tick) begin
         if (count == '0)
            count <= load_val;
         else
            count <= count - CNT_W'(1);
      end
   end

endmodule

// File: rtl/wdg_stage_ctl.sv
module wdg_stage_ctl
   import wdg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_wr,
   input  logic       poke,
   input  logic       expire,
   input  logic [1:0] limit,
   output wdg_stage_e stage,
   output logic       at_limit,
   output logic       irq1,
   output logic       irq2,
   output logic       rst_req
);

   logic advance;

   assign at_limit = (stage >= limit);
   assign advance  = expire && !at_limit && !cfg_wr && !poke;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage   <= STG_ARMED;
         irq1    <= 1'b0;
         irq2    <= 1'b0;
         rst_req <= 1'b0;
      end else begin
         irq1 <= advance && (stage == STG_ARMED);
         irq2 <= advance && (stage == STG_FIRST);
         if (cfg_wr || poke)
            stage <= STG_ARMED;
         else if (advance)
            stage <= wdg_stage_e'(stage + 2'd1);
         if (cfg_wr)
            rst_req <= 1'b0;
         else if (advance && (stage == STG_SECOND))
            rst_req <= 1'b1;
      end
   end

endmodule

// File: rtl/wdg_tristage.sv
module wdg_tristage
   import wdg_pkg::*;
#(
   parameter int PRE_LOG2 = 10,
   parameter int LEN_W    = 16,
   parameter int LOW_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [REG_W-1:0]  cfg_wdata,
   output logic [REG_W-1:0]  cfg_rdata,
   input  logic              poke_we,
   input  logic              dbg_halt,
   input  logic              glb_halt,
   output logic              irq_stage1,
   output logic              irq_stage2,
   output logic              rst_req
);

   localparam int CNT_W = LEN_W + LOW_W;

   generate
      if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len
         $error("wdg_tristage: LEN_W must be 1..16");
      end
      if (CNT_W > F_CNT_MAXW) begin : g_bad_cnt
         $error("wdg_tristage: LEN_W + LOW_W must not exceed 24");
      end
      if (PRE_LOG2 < 0 || PRE_LOG2 > 24) begin : g_bad_pre
         $error("wdg_tristage: PRE_LOG2 must be 0..24");
      end
   endgenerate

   logic [1:0]       mode_q;
   logic [LEN_W-1:0] len_q;
   logic             dstop_q;
   logic             gstop_q;
   logic             wr_unused;

   assign wr_unused = ^cfg_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= '0;
         len_q   <= '0;
         dstop_q <= 1'b0;
         gstop_q <= 1'b0;
      end else if (cfg_we) begin
         mode_q  <= cfg_wdata[F_MODE_LO +: 2];
         len_q   <= cfg_wdata[F_LEN_LO +: LEN_W];
         dstop_q <= cfg_wdata[B_DSTOP];
         gstop_q <= cfg_wdata[B_GSTOP];
      end
   end

   logic [LEN_W-1:0] len_src;
   logic [CNT_W-1:0] reload_val;

   assign len_src = cfg_we ? cfg_wdata[F_LEN_LO +: LEN_W] : len_q;

   generate
      if (LOW_W == 0) begin : g_reload_plain
         assign reload_val = len_src;
      end else begin : g_reload_shift
         assign reload_val = {len_src, {LOW_W{1'b0}}};
      end
   endgenerate

   wdg_stage_e       stage;
   logic             at_limit;
   logic             halted;
   logic             run;
   logic             restart;
   logic             tick;
   logic             expire;
   logic [CNT_W-1:0] count;

   assign halted  = (dstop_q && dbg_halt) || (gstop_q && glb_halt);
   assign run     = !at_limit && !halted;
   assign restart = cfg_we || poke_we;

   wdg_prescale #(
      .PRE_LOG2 (PRE_LOG2)
   ) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (restart),
      .run   (run),
      .tick  (tick)
   );

   wdg_countdown #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (restart),
      .load_val (reload_val),
      .tick     (tick),
      .count    (count),
      .expire   (expire)
   );

   wdg_stage_ctl u_stg (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_wr   (cfg_we),
      .poke     (poke_we),
      .expire   (expire),
      .limit    (mode_q),
      .stage    (stage),
      .at_limit (at_limit),
      .irq1     (irq_stage1),
      .irq2     (irq_stage2),
      .rst_req  (rst_req)
   );

   always_comb begin
      cfg_rdata                       = '0;
      cfg_rdata[F_MODE_LO +: 2]       = mode_q;
      cfg_rdata[F_STAGE_LO +: 2]      = stage;
      cfg_rdata[F_LEN_LO +: LEN_W]    = len_q;
      cfg_rdata[F_CNT_LO +: CNT_W]    = count;
      cfg_rdata[B_DSTOP]              = dstop_q;
      cfg_rdata[B_GSTOP]              = gstop_q;
   end

endmodule

// File: rtl/wdg_tristage_chk.sv
module wdg_tristage_chk
   import wdg_pkg::*;
#(
   parameter int LEN_W = 16,
   parameter int LOW_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_we,
   input logic [REG_W-1:0] cfg_wdata,
   input logic [REG_W-1:0] cfg_rdata,
   input logic             poke_we,
   input logic             dbg_halt,
   input logic             irq_stage1,
   input logic             irq_stage2,
   input logic             rst_req
);

   localparam int CNT_W = LEN_W + LOW_W;

   logic [1:0]       rd_mode;
   logic [1:0]       rd_stage;
   logic [CNT_W-1:0] rd_count;
   logic [CNT_W-1:0] rd_reload;

   assign rd_mode   = cfg_rdata[F_MODE_LO +: 2];
   assign rd_stage  = cfg_rdata[F_STAGE_LO +: 2];
   assign rd_count  = cfg_rdata[F_CNT_LO +: CNT_W];
   assign rd_reload = CNT_W'(cfg_rdata[F_LEN_LO +: LEN_W]) << LOW_W;

   AST_IRQ1_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      irq_stage1 |=> !irq_stage1); // R4

   AST_IRQ2_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      irq_stage2 |=> !irq_stage2); // R4

   AST_IRQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({irq_stage1, irq_stage2})); // R4

   AST_RST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_req && !cfg_we) |=> rst_req); // R6

   AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_wdata[F_MODE_LO +: 2] == 2'd0) |=> (!irq_stage1 && !irq_stage2 && !rst_req)); // R7

   AST_POKE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (poke_we && !cfg_we) |=> (rd_stage == 2'd0 && rd_count == rd_reload)); // R8

   AST_DBG_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_halt && cfg_rdata[B_DSTOP] && !cfg_we && !poke_we) |=> $stable(rd_count)); // R9

   AST_STAGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stage <= rd_mode); // R11

endmodule

bind wdg_tristage wdg_tristage_chk #(
   .LEN_W (LEN_W),
   .LOW_W (LOW_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_we     (cfg_we),
   .cfg_wdata  (cfg_wdata),
   .cfg_rdata  (cfg_rdata),
   .poke_we    (poke_we),
   .dbg_halt   (dbg_halt),
   .irq_stage1 (irq_stage1),
   .irq_stage2 (irq_stage2),
   .rst_req    (rst_req)
);

// File: tb/wdg_tristage_tb.sv
module wdg_tristage_tb;

   localparam int PRE_LOG2 = 2;
   localparam int LEN_W    = 16;
   localparam int LOW_W    = 2;
   localparam int PER_CLK  = 1 << PRE_LOG2;

   typedef struct {
      int kind;
      int at;
   } ev_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [63:0] cfg_wdata = '0;
   logic [63:0] cfg_rdata;
   logic        poke_we = 1'b0;
   logic        dbg_halt = 1'b0;
   logic        glb_halt = 1'b0;
   logic        irq_stage1;
   logic        irq_stage2;
   logic        rst_req;

   int  cyc = 0;
   int  tests = 0;
   int  fails = 0;
   bit  done = 1'b0;
   bit  rst_prev = 1'b0;
   ev_t exp_q[$];

   always #10 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   wdg_tristage #(
      .PRE_LOG2 (PRE_LOG2),
      .LEN_W    (LEN_W),
      .LOW_W    (LOW_W)
   ) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_wdata  (cfg_wdata),
      .cfg_rdata  (cfg_rdata),
      .poke_we    (poke_we),
      .dbg_halt   (dbg_halt),
      .glb_halt   (glb_halt),
      .irq_stage1 (irq_stage1),
      .irq_stage2 (irq_stage2),
      .rst_req    (rst_req)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint expv);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
      end
   endtask

   function automatic int period(input int len);
      return ((len << LOW_W) + 1) * PER_CLK;
   endfunction

   function automatic logic [63:0] mk(input int mode, input int len, input bit ds, input bit gs);
      return {18'd0, gs, ds, 24'd0, len[15:0], 2'd0, mode[1:0]};
   endfunction

   task automatic push(input int kind, input int at);
      ev_t e;
      e.kind = kind;
      e.at   = at;
      exp_q.push_back(e);
   endtask

   task automatic cfg_write(input logic [63:0] d, output int wc);
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_wdata = d;
      wc        = cyc + 1;
      @(negedge clk);
      cfg_we    = 1'b0;
      cfg_wdata = '0;
   endtask

   task automatic poke(output int pc);
      @(negedge clk);
      poke_we = 1'b1;
      pc      = cyc + 1;
      @(negedge clk);
      poke_we = 1'b0;
   endtask

   task automatic wait_until(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   task automatic drain(input string req);
      repeat (120) @(negedge clk);
      chk(exp_q.size() == 0, req, exp_q.size(), 0);
   endtask

   // monitor: pops the expected event queue on every observed event
   task automatic got(input int kind);
      ev_t e;
      if (exp_q.size() == 0) begin
         tests++;
         fails++;
         $display("FAIL R4/R5/R7 unexpected event actual=%0d expected=none (cycle %0d)", kind, cyc);
      end else begin
         e = exp_q.pop_front();
         chk(e.kind == kind, "R4 event kind", kind, e.kind);
         chk(e.at == cyc, "R3 event cycle", cyc, e.at);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (irq_stage1) got(1);
         if (irq_stage2) got(2);
         if (rst_req && !rst_prev) got(3);
         rst_prev = rst_req;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      int w;
      int p;
      int p2;
      int per;
      logic [23:0] ca;

      repeat (3) @(negedge clk);
      // R1: reset state
      chk(cfg_rdata == 64'd0, "R1 rdata", cfg_rdata, 0);
      chk({irq_stage1, irq_stage2, rst_req} == 3'b000, "R1 outputs", {irq_stage1, irq_stage2, rst_req}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2/R3/R4: full sequence with limit 3, length 3
      per = period(3);
      cfg_write(mk(3, 3, 1'b0, 1'b0), w);
      chk(cfg_rdata[1:0] == 2'd3, "R2 mode field", cfg_rdata[1:0], 3);
      chk(cfg_rdata[19:4] == 16'd3, "R2 length field", cfg_rdata[19:4], 3);
      chk(cfg_rdata[3:2] == 2'd0, "R2 stage field", cfg_rdata[3:2], 0);
      chk(cfg_rdata[43:20] == 24'd12, "R2 count field", cfg_rdata[43:20], 12);
      push(1, w + per);
      push(2, w + 2 * per);
      push(3, w + 3 * per);
      wait_until(w + 3 * per + 40);
      // R6: request still held
      chk(rst_req == 1'b1, "R6 reset held", rst_req, 1);
      chk(cfg_rdata[3:2] == 2'd3, "R4 stage reaches 3", cfg_rdata[3:2], 3);
      // R7: write zero disables
      cfg_write(64'd0, w);
      chk(rst_req == 1'b0, "R7 reset cleared", rst_req, 0);
      drain("R7 no events when off");

      // R5: limit 1
      cfg_write(mk(1, 3, 1'b0, 1'b0), w);
      push(1, w + per);
      wait_until(w + 3 * per + 20);
      chk(cfg_rdata[3:2] == 2'd1, "R5 stage held at 1", cfg_rdata[3:2], 1);
      chk(rst_req == 1'b0, "R5 no reset at limit 1", rst_req, 0);
      // R8: poke restarts a stopped channel
      poke(p);
      chk(cfg_rdata[3:2] == 2'd0, "R8 stage after poke", cfg_rdata[3:2], 0);
      push(1, p + per);
      wait_until(p + per + 5);
      cfg_write(64'd0, w);
      drain("R5 limit 1 drained");

      // R5: limit 2 with length 0
      per = period(0);
      cfg_write(mk(2, 0, 1'b0, 1'b0), w);
      push(1, w + per);
      push(2, w + 2 * per);
      wait_until(w + 10 * per);
      chk(cfg_rdata[3:2] == 2'd2, "R5 stage held at 2", cfg_rdata[3:2], 2);
      chk(rst_req == 1'b0, "R5 no reset at limit 2", rst_req, 0);
      cfg_write(64'd0, w);
      drain("R5 limit 2 drained");

      // R8: poke before expiry, and poke after stage 1
      per = period(3);
      cfg_write(mk(3, 3, 1'b0, 1'b0), w);
      wait_until(w + 30);
      poke(p);
      push(1, p + per);
      wait_until(p + per + 10);
      poke(p2);
      chk(cfg_rdata[43:20] == 24'd12, "R8 count reloaded", cfg_rdata[43:20], 12);
      push(1, p2 + per);
      wait_until(p2 + per + 5);
      cfg_write(64'd0, w);
      drain("R8 poke drained");

      // R9: debug stop enabled
      cfg_write(mk(3, 3, 1'b1, 1'b0), w);
      push(1, w + per + 20);
      wait_until(w + 10);
      @(negedge clk);
      dbg_halt = 1'b1;
      repeat (5) @(negedge clk);
      ca = cfg_rdata[43:20];
      repeat (5) @(negedge clk);
      chk(cfg_rdata[43:20] == ca, "R9 count frozen", cfg_rdata[43:20], ca);
      repeat (10) @(negedge clk);
      dbg_halt = 1'b0;
      wait_until(w + per + 25);
      cfg_write(64'd0, w);
      drain("R9 debug stop drained");

      // R10: global stop enabled; R9: debug halt ignored with bit clear
      cfg_write(mk(3, 3, 1'b0, 1'b1), w);
      push(1, w + per + 15);
      wait_until(w + 5);
      @(negedge clk);
      glb_halt = 1'b1;
      repeat (15) @(negedge clk);
      glb_halt = 1'b0;
      dbg_halt = 1'b1;
      repeat (25) @(negedge clk);
      dbg_halt = 1'b0;
      wait_until(w + per + 20);
      cfg_write(64'd0, w);
      drain("R10 global stop drained");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule